// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds two 64-bit packed operands as a set of independent integer lanes. A single adder runs across the word, and its carry chain is cut at lane edges. A two-bit lane configuration selects the lane layout: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one unbroken 64-bit lane. Every lane performs the same operation in the same cycle. The operation is an add, or a subtract when the subtract select is set. Subtraction inverts the second operand and injects a carry of one at the bottom of each lane.

Each lane either wraps modulo two to the power of its width, or saturates at its own limits. The limits follow the signed or unsigned interpretation selected by the sign input. Alongside the packed result, the block reports which lanes were clamped. Operands are captured with a valid strobe, and the result appears one clock later together with a matching valid.

Top module: `simd_sat_adder`

## Requirements
- R1: After reset, out_valid, result and lane_sat are all zero until the first accepted operation.
- R2: An operation presented with in_valid high on a rising edge appears on result, lane_sat and out_valid after that same edge. out_valid is low after any edge at which in_valid was low.
- R3: With lane_cfg = 0 (eight 8-bit lanes, lane k in bits 8k+7:8k) and sat_en low, each lane equals (a_k ± b_k) mod 256, and no carry or borrow passes between lanes.
- R4: With lane_cfg = 1 (four 16-bit lanes) or lane_cfg = 2 (two 32-bit lanes) and sat_en low, each lane wraps modulo 2^16 or 2^32 independently.
- R5: With lane_cfg = 3 the whole 64-bit word is one lane with an uncut carry chain. In this mode only lane_sat bit 0 may ever be set.
- R6: Unsigned saturating add (sat_en=1, signed_en=0, sub_en=0): a lane whose sum carries out of its top bit returns all ones.
- R7: Signed saturating add or subtract (sat_en=1, signed_en=1): positive overflow returns the lane's largest positive value (0 followed by ones). Negative overflow returns its most negative value (1 followed by zeros).
- R8: Unsigned saturating subtract (sat_en=1, signed_en=0, sub_en=1): a lane whose difference would fall below zero returns all zeros.
- R9: lane_sat bit k is set exactly when lane k overflowed with sat_en high. Bits for lanes that do not exist in the chosen layout are zero, and all bits are zero when sat_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and selects are taken on this edge |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand (subtrahend when sub_en is high) |
| lane_cfg | input | 2 | Lane layout: 0 = 8x8, 1 = 4x16, 2 = 2x32, 3 = 1x64 |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| sub_en | input | 1 | 1 = op_a minus op_b, 0 = op_a plus op_b |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 64 | Packed lane results |
| lane_sat | output | 8 | Per-lane clamp indicator, bit k for lane k |

## Verification
Clamping in one lane and an exact wrap-free or carry-cut result in the adjacent lane occur in the same cycle. A wrong cut, or a clamp value spread to the wrong segments, shows up only when both happen together. Directed vectors therefore pair an overflowing lane with a neighbour whose raw sum would absorb a stray carry, such as 0xFF+0x01 beside 0x00+0x00. Random vectors then mix all layouts and modes back to back. Each result is judged against a per-lane reference in a scoreboard queue, and the lane flags are compared as a separate item.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
   localparam int SEG_COUNT = 8;
   localparam int CFG_W     = 2;

   typedef enum logic [CFG_W-1:0] {
      LANE_8X  = 2'd0,
      LANE_16X = 2'd1,
      LANE_32X = 2'd2,
      LANE_64X = 2'd3
   } lane_cfg_e;
endpackage

// File: rtl/simd_seg_chain.sv
module simd_seg_chain #(
   parameter int SEG_W = 8,
   parameter int SEG_N = simd_add_pkg::SEG_COUNT,
   parameter int SI    = $clog2(SEG_N),
   parameter int DW    = SEG_W * SEG_N
) (
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    b,
   input  logic [SI-1:0]    cfg,
   input  logic             sub,
   output logic [DW-1:0]    sum,
   output logic [SEG_N-1:0] cout,
   output logic [SEG_N-1:0] cmsb
);
   logic [SI-1:0]    mask;
   logic [SEG_N-1:0] first;

   assign mask = ~({SI{1'b1}} << cfg);

   always_comb begin
      for (int s = 0; s < SEG_N; s++) begin
         first[s] = ((SI'(s) & mask) == '0);
      end
   end

   for (genvar s = 0; s < SEG_N; s++) begin : g_seg
      logic [SEG_W-1:0] aa, bb, low;
      logic             ci;
      assign aa = a[s*SEG_W +: SEG_W];
      assign bb = b[s*SEG_W +: SEG_W] ^ {SEG_W{sub}};
      if (s == 0) begin : g_base
         assign ci = sub;
      end else begin : g_link
         assign ci = first[s] ? sub : cout[s-1];
      end
      assign low = {1'b0, aa[SEG_W-2:0]} + {1'b0, bb[SEG_W-2:0]}
                 + {{(SEG_W-1){1'b0}}, ci};
      assign cmsb[s] = low[SEG_W-1];
      assign sum[s*SEG_W +: SEG_W-1] = low[SEG_W-2:0];
      assign sum[s*SEG_W + SEG_W-1]  = aa[SEG_W-1] ^ bb[SEG_W-1] ^ low[SEG_W-1];
      assign cout[s] = (aa[SEG_W-1] & bb[SEG_W-1]) | (aa[SEG_W-1] & low[SEG_W-1])
                     | (bb[SEG_W-1] & low[SEG_W-1]);
   end
endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp #(
   parameter int SEG_W = 8,
   parameter int SEG_N = simd_add_pkg::SEG_COUNT,
   parameter int SI    = $clog2(SEG_N),
   parameter int DW    = SEG_W * SEG_N
) (
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    raw,
   input  logic [SEG_N-1:0] cout,
   input  logic [SEG_N-1:0] cmsb,
   input  logic [SI-1:0]    cfg,
   input  logic             sat_en,
   input  logic             signed_en,
   input  logic             sub_en,
   output logic [DW-1:0]    res,
   output logic [SEG_N-1:0] lane_sat
);
   localparam logic [SEG_W-1:0] ONES = {SEG_W{1'b1}};
   localparam logic [SEG_W-1:0] TOPB = {1'b1, {(SEG_W-1){1'b0}}};

   logic [SI-1:0]    mask;
   logic [SEG_N-1:0] last, ovf, hit, neg;

   assign mask = ~({SI{1'b1}} << cfg);

   always_comb begin
      for (int s = 0; s < SEG_N; s++) begin
         last[s] = ((SI'(s) & mask) == mask);
         if (signed_en) ovf[s] = cout[s] ^ cmsb[s];
         else           ovf[s] = sub_en ? ~cout[s] : cout[s];
         hit[s] = sat_en & last[s] & ovf[s];
         neg[s] = a[s*SEG_W + SEG_W-1];
      end
   end

   always_comb begin
      logic [SI-1:0]    g;
      logic [SEG_W-1:0] cv;
      lane_sat = '0;
      res      = raw;
      for (int s = 0; s < SEG_N; s++) begin
         g = SI'(s) | mask;
         if (!signed_en)  cv = sub_en ? '0 : ONES;
         else if (neg[g]) cv = last[s] ? TOPB : '0;
         else             cv = last[s] ? ~TOPB : ONES;
         if (hit[g]) res[s*SEG_W +: SEG_W] = cv;
         if (hit[s]) lane_sat[SI'(s) >> cfg] = 1'b1;
      end
   end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
   parameter int SEG_W = 8,
   parameter int SEG_N = simd_add_pkg::SEG_COUNT,
   parameter int SI    = $clog2(SEG_N),
   parameter int DW    = SEG_W * SEG_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [DW-1:0]    op_a,
   input  logic [DW-1:0]    op_b,
   input  logic [1:0]       lane_cfg,
   input  logic             sat_en,
   input  logic             signed_en,
   input  logic             sub_en,
   output logic             out_valid,
   output logic [DW-1:0]    result,
   output logic [SEG_N-1:0] lane_sat
);
   import simd_add_pkg::*;

   if (SEG_W < 2) begin : g_bad_seg
      $error("SEG_W must be at least 2");
   end
   if (SEG_N != 8) begin : g_bad_count
      $error("SEG_N must be 8 so that four layouts fit the two-bit select");
   end

   logic [DW-1:0]    raw_sum, clamped;
   logic [SEG_N-1:0] seg_cout, seg_cmsb, sat_now;
   logic [SI-1:0]    cfg_w;

   assign cfg_w = SI'(lane_cfg);

   simd_seg_chain #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_chain (
      .a(op_a), .b(op_b), .cfg(cfg_w), .sub(sub_en),
      .sum(raw_sum), .cout(seg_cout), .cmsb(seg_cmsb)
   );

   simd_lane_clamp #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_clamp (
      .a(op_a), .raw(raw_sum), .cout(seg_cout), .cmsb(seg_cmsb), .cfg(cfg_w),
      .sat_en(sat_en), .signed_en(signed_en), .sub_en(sub_en),
      .res(clamped), .lane_sat(sat_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         lane_sat  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= clamped;
            lane_sat <= sat_now;
         end
      end
   end

   p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_wrap_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sat_en) |=> (lane_sat == '0));
   p_full_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_cfg == LANE_64X) |=> (lane_sat[SEG_N-1:1] == '0));
   p_uns_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && !signed_en && !sub_en && lane_cfg == LANE_8X)
      |=> (!lane_sat[0] || result[SEG_W-1:0] == {SEG_W{1'b1}}));
   p_sgn_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && signed_en && lane_cfg == LANE_8X)
      |=> (!lane_sat[0] || result[SEG_W-2:0] == {(SEG_W-1){~result[SEG_W-1]}}));
   p_uns_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sat_en && !signed_en && sub_en && lane_cfg == LANE_8X)
      |=> (!lane_sat[0] || result[SEG_W-1:0] == '0));
endmodule

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic [1:0]  lane_cfg = '0;
   logic        sat_en = 1'b0, signed_en = 1'b0, sub_en = 1'b0;
   logic        out_valid;
   logic [63:0] result;
   logic [7:0]  lane_sat;

   int checks = 0;
   int fails  = 0;
   logic iv_edge = 1'b0;
   bit   done = 1'b0;

   typedef struct {
      logic [63:0] r;
      logic [7:0]  f;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_sat_adder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .lane_cfg(lane_cfg), .sat_en(sat_en), .signed_en(signed_en), .sub_en(sub_en),
      .out_valid(out_valid), .result(result), .lane_sat(lane_sat)
   );

   function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [1:0] cfg, input logic sat,
                                 input logic sgn, input logic sub,
                                 output logic [63:0] r, output logic [7:0] f);
      int w = 8 << cfg;
      int n = 8 >> cfg;
      logic [65:0] m = (66'd1 << w) - 66'd1;
      logic [65:0] h = 66'd1 << (w - 1);
      r = '0;
      f = '0;
      for (int k = 0; k < n; k++) begin
         logic [65:0] ua, ub, full, lane, cv;
         logic signed [65:0] sa, sb2, rs;
         logic ov;
         ua = ({2'b0, a} >> (k * w)) & m;
         ub = ({2'b0, b} >> (k * w)) & m;
         full = sub ? ua - ub : ua + ub;
         if (!sgn) begin
            ov = sub ? (ua < ub) : full[w];
            cv = sub ? 66'd0 : m;
         end else begin
            sa  = $signed(ua ^ h) - $signed(h);
            sb2 = $signed(ub ^ h) - $signed(h);
            rs  = sub ? sa - sb2 : sa + sb2;
            if (rs > $signed(h - 66'd1)) begin ov = 1'b1; cv = h - 66'd1; end
            else if (rs < -$signed(h))   begin ov = 1'b1; cv = h; end
            else begin ov = 1'b0; cv = '0; end
         end
         lane = (sat && ov) ? cv : (full & m);
         r = r | (lane[63:0] << (k * w));
         f[k] = sat & ov;
      end
   endfunction

   task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] cfg,
                       input logic sat, input logic sgn, input logic sub);
      exp_t e;
      @(negedge clk);
      op_a = a; op_b = b; lane_cfg = cfg;
      sat_en = sat; signed_en = sgn; sub_en = sub; in_valid = 1'b1;
      model(a, b, cfg, sat, sgn, sub, e.r, e.f);
      if (sat)           e.tag = sgn ? "R7" : (sub ? "R8" : "R6");
      else if (cfg == 0) e.tag = "R3";
      else if (cfg == 3) e.tag = "R5";
      else               e.tag = "R4";
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always @(posedge clk) iv_edge <= in_valid;

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (out_valid !== iv_edge) begin
            fails++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, iv_edge);
         end
         if (out_valid) begin
            if (sb.size() == 0) begin
               fails++;
               $display("FAIL R2 result with empty scoreboard actual=1 expected=0");
            end else begin
               exp_t e;
               e = sb.pop_front();
               checks++;
               if (result !== e.r) begin
                  fails++;
                  $display("FAIL %s result actual=%h expected=%h", e.tag, result, e.r);
               end
               checks++;
               if (lane_sat !== e.f) begin
                  fails++;
                  $display("FAIL R9 flags (%s) actual=%b expected=%b", e.tag, lane_sat, e.f);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== '0 || lane_sat !== '0) begin
         fails++;
         $display("FAIL R1 reset actual=%0b/%h/%b expected=0/0/0", out_valid, result, lane_sat);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== '0) begin
         fails++;
         $display("FAIL R1 after release actual=%0b/%h expected=0/0", out_valid, result);
      end
      // R3: byte lanes wrap, carry stays inside the lane
      send(64'h00FF_7F80_FFFF_0001, 64'h0001_0180_0101_00FF, 2'd0, 0, 0, 0);
      send(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 0, 0, 1);
      // R4: 16 and 32 bit lanes
      send(64'hFFFF_0000_8000_1234, 64'h0001_FFFF_8000_1111, 2'd1, 0, 0, 0);
      send(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 2'd2, 0, 0, 1);
      // R5: full width
      send(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 0, 0, 0);
      send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 2'd3, 1, 0, 0);
      idle();
      // R6: unsigned clamp beside an untouched neighbour
      send(64'h00FF_00FF_80F0_1000, 64'h0001_0000_8010_2000, 2'd0, 1, 0, 0);
      // R7: signed clamps both directions
      send(64'h7F80_0180_7F00_8001, 64'h01FF_7F80_0000_FFFE, 2'd0, 1, 1, 0);
      send(64'h8000_7FFF_0000_8000, 64'h0001_FFFF_0001_0001, 2'd1, 1, 1, 1);
      send(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 2'd2, 1, 1, 0);
      // R8: unsigned floor at zero
      send(64'h0005_0100_0000_FF00, 64'h0006_0001_0001_0001, 2'd0, 1, 0, 1);
      send(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 2'd3, 1, 0, 1);
      idle();
      idle();
      for (int i = 0; i < 400; i++) begin
         logic [31:0] rz;
         rz = $urandom;
         send({$urandom, $urandom}, {$urandom, $urandom}, rz[1:0], rz[2], rz[3], rz[4]);
         if (rz[7:5] == 3'd0) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R2 pending results actual=%0d expected=0", sb.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule